// File: doc/BRIEF.md
# SDRAM Open-Row Read Command Sequencer

This block accepts single-word read requests, each carrying a bank, a row and a column, and turns each one into the command sequence an SDRAM needs. For each of the four banks it keeps a record of whether a row is open and which row that is. A request that targets the row already open in its bank goes out as a column read in the very next cycle. A request that targets a closed bank first opens the row. A request that targets a different row in a bank with an open row closes the old row, waits the precharge delay, opens the new row and waits the row-to-column delay before the read.

Read data comes back on the memory data input a programmable number of cycles after each read command. The block samples it at that cycle and hands it to the host after an extra programmable pipeline delay. That extra delay applies only when the read buffer is enabled. The host sees a ready signal that accepts one hit per cycle and drops for the duration of any precharge or activate sequence. All timing values are static inputs.

Top module: `sdram_row_sequencer`

## Requirements
- R1: After reset no bank has an open row. The command pins {cs_n, ras_n, cas_n, we_n} read 4'b0111 (no-op), `req_ready` is 1 and `rd_valid` is 0. As a result, the first request to any bank always starts with an activate.
- R2: When a request is accepted and its bank has the requested row open (a hit), the cycle after acceptance carries a read command, 4'b0101, with `sd_ba` = bank and `sd_addr` = column zero-extended (bit 10 low). `req_ready` stays 1, so hits are accepted and issued one per cycle.
- R3: When the requested bank has no open row, the cycle after acceptance carries an activate command, 4'b0011, with `sd_addr` = row and `sd_ba` = bank. The read follows exactly RCD cycles after the activate, with no-ops between them.
- R4: When the requested bank has a different row open, the cycle after acceptance carries a precharge command, 4'b0010, with `sd_addr` = 0 (bit 10 low, this bank only) and `sd_ba` = bank. The activate comes exactly RP cycles after the precharge, and the read exactly RCD cycles after the activate.
- R5: `req_ready` is 0 from the cycle after a miss is accepted until the cycle in which its read command appears. In that cycle it is 1 again.
- R6: A row opened by an activate stays recorded as open until its own bank is precharged. Opening or closing rows in one bank does not change whether a request to another bank's open row counts as a hit.
- R7: Let a read command appear in cycle c. The block samples `sd_dq_in` in cycle c+CL. With the buffer enabled, the sampled word appears on `rd_data` with `rd_valid` = 1 in cycle c+CL+PIPE. With the buffer disabled, it appears in cycle c+CL+1 whatever PIPE holds.
- R8: `rd_valid` is high for exactly one cycle per read command issued, and the words come back in command order.
- R9: A value of 0 on `cfg_rcd`, `cfg_rp`, `cfg_cl` or `cfg_pipe` behaves exactly as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the SDRAM command pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_rcd | input | 4 | Activate-to-read delay in cycles (static) |
| cfg_rp | input | 4 | Precharge-to-activate delay in cycles (static) |
| cfg_cl | input | 4 | Read-command-to-data latency in cycles (static) |
| cfg_pipe | input | 4 | Extra return pipeline delay in cycles (static) |
| cfg_buf_en | input | 1 | Enables the pipeline delay of the return path |
| req_valid | input | 1 | Host read request present |
| req_ready | output | 1 | Request accepted at the edge where valid and ready are both 1 |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row of the request |
| req_col | input | 9 | Column of the request |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | 13 | SDRAM address pins |
| sd_ba | output | 2 | SDRAM bank pins |
| sd_dq_in | input | 32 | SDRAM read data |
| rd_valid | output | 1 | Read data valid, one pulse per read |
| rd_data | output | 32 | Read data word |

## Verification
Two functions can fall in the same cycle: an earlier read's word returning on `rd_valid`, and the sequencer driving a new command (a back-to-back hit, a precharge or an activate) on the pins. The bench provokes this with an eight-column stream of hits that is followed at once by a miss to the same bank. It sweeps short and long RCD, RP, CL and pipeline settings, with the buffer on and off, so that returns line up with every step of the miss sequence. A command checker compares the pins cycle by cycle against the expected sequence. A separate return monitor compares each returned word and its arrival cycle against values computed from the command it belongs to.

// File: rtl/sdr_seq_pkg.sv
// Shared definitions for the SDRAM open-row read sequencer.
// Assumes commands are encoded on {cs_n, ras_n, cas_n, we_n}.
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

endpackage

// File: rtl/sdr_row_table.sv
// Open-row table: one entry per bank, holding an open flag and the row number.
// Looks up the bank and row of the current request combinationally.
// Assumes an activate and a precharge never target the same bank in one cycle.
module sdr_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit,
    input  logic              upd_open,
    input  logic              upd_close,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    localparam int NB = 1 << BANK_W;

    logic [NB-1:0]    open_v;
    logic [ROW_W-1:0] row_a [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [BANK_W-1:0] IDX = BANK_W'(b);
        logic             open_q;
        logic [ROW_W-1:0] row_q;

        // Record an activate or precharge aimed at this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (upd_open && upd_bank == IDX) begin
                open_q <= 1'b1;
                row_q  <= upd_row;
            end else if (upd_close && upd_bank == IDX) begin
                open_q <= 1'b0;
            end
        end

        assign open_v[b] = open_q;
        assign row_a[b]  = row_q;
    end

    // Compare the request against the entry of its bank.
    always_comb begin
        lk_open = open_v[lk_bank];
        lk_hit  = lk_open && (row_a[lk_bank] == lk_row);
    end

    // R6
    open_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_open |=> (open_v[$past(upd_bank)] && row_a[$past(upd_bank)] == $past(upd_row)));

    // R6
    close_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_close && !upd_open) |=> !open_v[$past(upd_bank)]);

endmodule

// File: rtl/sdr_cmd_fsm.sv
// Command sequencer: accepts one request per cycle in idle. A hit issues a read
// at once. A miss runs precharge, activate and read with RP and RCD counted out
// by a single down-counter. All pin values are registered.
// Assumes the timing inputs stay constant while requests are in flight.
module sdr_cmd_fsm
    import sdr_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_rcd,
    input  logic [LAT_W-1:0]  cfg_rp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              lk_open,
    input  logic              lk_hit,
    output logic              tbl_open,
    output logic              tbl_close,
    output logic [BANK_W-1:0] tbl_bank,
    output logic [ROW_W-1:0]  tbl_row,
    output sd_cmd_e           cmd,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic [BANK_W-1:0] cmd_ba,
    output logic              rd_now
);
    typedef enum logic [1:0] {S_IDLE, S_RP, S_RCD} st_e;

    st_e               st_q, st_d;
    logic [LAT_W-1:0]  cnt_q, cnt_d;
    logic [BANK_W-1:0] pb_q, pb_d;
    logic [ROW_W-1:0]  pr_q, pr_d;
    logic [COL_W-1:0]  pc_q, pc_d;
    sd_cmd_e           cmd_q, cmd_d;
    logic [ROW_W-1:0]  addr_q, addr_d;
    logic [BANK_W-1:0] ba_q, ba_d;
    logic [LAT_W-1:0]  rcd_eff, rp_eff;

    // Zero timing values are treated as one cycle.
    always_comb begin
        rcd_eff = (cfg_rcd == '0) ? LAT_W'(1) : cfg_rcd;
        rp_eff  = (cfg_rp  == '0) ? LAT_W'(1) : cfg_rp;
    end

    // Next command, next state and table updates.
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        pb_d      = pb_q;
        pr_d      = pr_q;
        pc_d      = pc_q;
        cmd_d     = CMD_NOP;
        addr_d    = '0;
        ba_d      = '0;
        tbl_open  = 1'b0;
        tbl_close = 1'b0;
        req_ready = (st_q == S_IDLE);
        case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    ba_d = req_bank;
                    if (lk_hit) begin
                        cmd_d               = CMD_RD;
                        addr_d[COL_W-1:0]   = req_col;
                    end else begin
                        pb_d = req_bank;
                        pr_d = req_row;
                        pc_d = req_col;
                        if (lk_open) begin
                            cmd_d     = CMD_PRE;
                            tbl_close = 1'b1;
                            cnt_d     = rp_eff - 1'b1;
                            st_d      = S_RP;
                        end else begin
                            cmd_d    = CMD_ACT;
                            addr_d   = req_row;
                            tbl_open = 1'b1;
                            cnt_d    = rcd_eff - 1'b1;
                            st_d     = S_RCD;
                        end
                    end
                end
            end
            S_RP: begin
                if (cnt_q == '0) begin
                    cmd_d    = CMD_ACT;
                    addr_d   = pr_q;
                    ba_d     = pb_q;
                    tbl_open = 1'b1;
                    cnt_d    = rcd_eff - 1'b1;
                    st_d     = S_RCD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_RCD: begin
                if (cnt_q == '0) begin
                    cmd_d             = CMD_RD;
                    addr_d[COL_W-1:0] = pc_q;
                    ba_d              = pb_q;
                    st_d              = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Table updates name the request in idle and the pending miss otherwise.
    always_comb begin
        tbl_bank = (st_q == S_IDLE) ? req_bank : pb_q;
        tbl_row  = (st_q == S_IDLE) ? req_row  : pr_q;
    end

    // State, pending request and registered pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            pb_q   <= '0;
            pr_q   <= '0;
            pc_q   <= '0;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pb_q   <= pb_d;
            pr_q   <= pr_d;
            pc_q   <= pc_d;
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            ba_q   <= ba_d;
        end
    end

    assign cmd      = cmd_q;
    assign cmd_addr = addr_q;
    assign cmd_ba   = ba_q;
    assign rd_now   = (cmd_q == CMD_RD);

    // R2
    hit_reads_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (cmd_q == CMD_RD));

    // R5
    pre_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE || cmd_q == CMD_ACT) |-> !req_ready);

    // R3
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT && rcd_eff > LAT_W'(1)) |=> (cmd_q == CMD_NOP));

    // R4
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE && rp_eff > LAT_W'(1)) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdr_read_return.sv
// Read return path: a tag shift line marks the cycle CL after each read
// command, in which the data input is sampled. A delay line then adds the
// pipeline delay when the buffer is enabled (one stage otherwise).
// Assumes CL and the pipeline delay are static while reads are in flight.
module sdr_read_return #(
    parameter int DW    = 32,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_pipe,
    input  logic             cfg_buf_en,
    input  logic             rd_now,
    input  logic [DW-1:0]    dq_in,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << LAT_W;
    localparam int OUT_W = LAT_W + 2;

    logic [DEPTH-1:0] tag_sr;
    logic [DEPTH-1:0] dl_v;
    logic [DW-1:0]    dl_d [DEPTH];
    logic [LAT_W-1:0] cl_idx, pipe_idx;
    logic             capture;
    logic [OUT_W-1:0] outst_q;

    // Tap positions from the effective latencies (zero counts as one).
    always_comb begin
        cl_idx   = (cfg_cl == '0) ? '0 : cfg_cl - 1'b1;
        pipe_idx = (!cfg_buf_en || cfg_pipe == '0) ? '0 : cfg_pipe - 1'b1;
        capture  = tag_sr[cl_idx];
    end

    // Shift the read tags and the sampled words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_sr <= '0;
            dl_v   <= '0;
            for (int j = 0; j < DEPTH; j++) dl_d[j] <= '0;
        end else begin
            tag_sr  <= {tag_sr[DEPTH-2:0], rd_now};
            dl_v    <= {dl_v[DEPTH-2:0], capture};
            dl_d[0] <= dq_in;
            for (int j = 1; j < DEPTH; j++) dl_d[j] <= dl_d[j-1];
        end
    end

    assign rd_valid = dl_v[pipe_idx];
    assign rd_data  = dl_d[pipe_idx];

    // Count reads issued but not yet returned, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outst_q <= '0;
        else if (rd_now && !rd_valid)
            outst_q <= outst_q + 1'b1;
        else if (!rd_now && rd_valid)
            outst_q <= outst_q - 1'b1;
    end

    // R8
    no_orphan_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (outst_q != '0));

    // R7
    no_orphan_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (outst_q != '0));

endmodule

// File: rtl/sdram_row_sequencer.sv
// Top of the SDRAM open-row read sequencer: joins the open-row table, the
// command sequencer and the read return path. Drives the SDRAM command pins
// and returns one data word per read request.
// Assumes COL_W <= 10 so that address bit 10 stays low on reads.
module sdram_row_sequencer
    import sdr_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DW     = 32,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_rcd,
    input  logic [LAT_W-1:0]  cfg_rp,
    input  logic [LAT_W-1:0]  cfg_cl,
    input  logic [LAT_W-1:0]  cfg_pipe,
    input  logic              cfg_buf_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    input  logic [DW-1:0]     sd_dq_in,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    logic              lk_open, lk_hit;
    logic              tbl_open, tbl_close;
    logic [BANK_W-1:0] tbl_bank;
    logic [ROW_W-1:0]  tbl_row;
    sd_cmd_e           cmd_w;
    logic              rd_now;

    sdr_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(req_bank), .lk_row(req_row),
        .lk_open(lk_open), .lk_hit(lk_hit),
        .upd_open(tbl_open), .upd_close(tbl_close),
        .upd_bank(tbl_bank), .upd_row(tbl_row)
    );

    sdr_cmd_fsm #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .LAT_W(LAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_rcd(cfg_rcd), .cfg_rp(cfg_rp),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .lk_open(lk_open), .lk_hit(lk_hit),
        .tbl_open(tbl_open), .tbl_close(tbl_close),
        .tbl_bank(tbl_bank), .tbl_row(tbl_row),
        .cmd(cmd_w), .cmd_addr(sd_addr), .cmd_ba(sd_ba),
        .rd_now(rd_now)
    );

    sdr_read_return #(.DW(DW), .LAT_W(LAT_W)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .cfg_cl(cfg_cl), .cfg_pipe(cfg_pipe), .cfg_buf_en(cfg_buf_en),
        .rd_now(rd_now), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_w;

endmodule

// File: tb/test_sdram_row_sequencer.sv
`timescale 1ns/1ps
module test_sdram_row_sequencer;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rcd = 4'd1, cfg_rp = 4'd1, cfg_cl = 4'd1, cfg_pipe = 4'd1;
    logic        cfg_buf_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic [31:0] sd_dq = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  pins;

    sdram_row_sequencer i_sdram_row_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_rcd(cfg_rcd), .cfg_rp(cfg_rp), .cfg_cl(cfg_cl), .cfg_pipe(cfg_pipe),
        .cfg_buf_en(cfg_buf_en),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dq_in(sd_dq),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rcd_e, rp_e, cl_e, pipe_e;
    int b_open [4];
    int b_row  [4];
    int m_row  [4];
    logic [31:0] sch_d [64];
    bit          sch_v [64];
    logic [31:0] exp_d [256];
    int          exp_t [256];
    int head = 0, tail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic logic [31:0] mkdat(input logic [1:0] b, input logic [12:0] r,
                                          input logic [8:0] c);
        return {b, r, c, 8'hA5};
    endfunction

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // SDRAM data model and return monitor (R7, R8)
    always @(negedge clk) begin
        sd_dq = sch_v[cyc % 64] ? sch_d[cyc % 64] : 32'h0;
        sch_v[cyc % 64] = 1'b0;
        if (rst_n && pins == P_ACT) m_row[sd_ba] = int'(sd_addr);
        if (rst_n && pins == P_RD) begin
            sch_d[(cyc + cl_e) % 64] = mkdat(sd_ba, 13'(m_row[sd_ba]), sd_addr[8:0]);
            sch_v[(cyc + cl_e) % 64] = 1'b1;
            exp_d[tail % 256] = mkdat(sd_ba, 13'(m_row[sd_ba]), sd_addr[8:0]);
            exp_t[tail % 256] = cyc + cl_e + pipe_e;
            tail++;
        end
        if (rd_valid) begin
            if (head == tail) begin
                chk(1'b0, "R8", "return with no read outstanding", 1, 0);
            end else begin
                chk(exp_t[head % 256] == cyc, "R7", "return cycle", cyc, exp_t[head % 256]);
                chk(rd_data == exp_d[head % 256], "R8", "return data in order",
                    int'(rd_data), int'(exp_d[head % 256]));
                head++;
            end
        end else if (head != tail && exp_t[head % 256] <= cyc) begin
            chk(1'b0, "R8", "missing return", 0, 1);
            head++;
        end
    end

    // One request, waits for it and checks every pin cycle up to its read.
    task automatic do_req(input int b, input int r, input int c, input string req);
        int pre_off, act_off, rd_off, bad_off;
        bit hit, ok, rdy_ok;
        logic [3:0] exp_c, act_c;
        hit = (b_open[b] != 0) && (b_row[b] == r);
        pre_off = 0; act_off = 0;
        if (hit) rd_off = 1;
        else if (b_open[b] != 0) begin pre_off = 1; act_off = 1 + rp_e; rd_off = act_off + rcd_e; end
        else begin act_off = 1; rd_off = 1 + rcd_e; end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_row = 13'(r); req_col = 9'(c);
        @(negedge clk);
        req_valid = 1'b0;
        ok = 1'b1; rdy_ok = 1'b1; bad_off = 0; exp_c = P_NOP; act_c = P_NOP;
        for (int off = 1; off <= rd_off; off++) begin
            logic [3:0] ec;
            logic [12:0] ea;
            ec = P_NOP; ea = '0;
            if (off == rd_off) begin ec = P_RD; ea = 13'(c); end
            else if (off == act_off) begin ec = P_ACT; ea = 13'(r); end
            else if (off == pre_off) begin ec = P_PRE; ea = '0; end
            if (ok && (pins != ec || (ec != P_NOP && (sd_addr != ea || sd_ba != 2'(b))))) begin
                ok = 1'b0; bad_off = off; exp_c = ec; act_c = pins;
            end
            if (req_ready != (off == rd_off)) rdy_ok = 1'b0;
            if (off < rd_off) @(negedge clk);
        end
        chk(ok, req, $sformatf("command sequence, offset %0d", bad_off), int'(act_c), int'(exp_c));
        chk(rdy_ok, "R5", "ready low during miss, high at read", 0, 1);
        b_open[b] = 1; b_row[b] = r;
    endtask

    // Eight reads to one row: the first may open it, the rest stream as hits.
    task automatic do_burst(input int b, input int r, input int c0, input string req);
        bit ok;
        do_req(b, r, c0, req);
        ok = 1'b1;
        for (int k = 1; k < 8; k++) begin
            req_valid = 1'b1; req_bank = 2'(b); req_row = 13'(r); req_col = 9'(c0 + k);
            @(negedge clk);
            if (pins != P_RD || sd_addr != 13'(c0 + k) || sd_ba != 2'(b) || !req_ready) ok = 1'b0;
        end
        req_valid = 1'b0;
        chk(ok, "R2", "back-to-back hits one per cycle", int'(ok), 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) sch_v[i] = 1'b0;
        // R9: the sweep includes zero timing values, expected as one cycle.
        foreach_cfg: for (int rc = 0; rc < 3; rc++)
        for (int rp = 0; rp < 2; rp++)
        for (int cl = 0; cl < 3; cl++)
        for (int pp = 0; pp < 2; pp++)
        for (int be = 0; be < 2; be++) begin
            cfg_rcd = 4'((rc == 0) ? 0 : (rc == 1) ? 1 : 3);
            cfg_rp  = 4'((rp == 0) ? 0 : 2);
            cfg_cl  = 4'((cl == 0) ? 0 : cl + 1);
            cfg_pipe = 4'((pp == 0) ? 0 : 3);
            cfg_buf_en = be[0];
            rcd_e = eff(int'(cfg_rcd)); rp_e = eff(int'(cfg_rp)); cl_e = eff(int'(cfg_cl));
            pipe_e = be ? eff(int'(cfg_pipe)) : 1;
            for (int i = 0; i < 4; i++) b_open[i] = 0;
            @(negedge clk); rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1: reset state at the ports
            chk(req_ready && pins == P_NOP && !rd_valid, "R1", "reset state",
                int'({req_ready, pins, rd_valid}), int'({1'b1, P_NOP, 1'b0}));
            do_req(0, 5, 1, "R1");       // first access to bank 0 activates
            do_req(0, 5, 2, "R2");       // hit
            do_req(1, 7, 3, "R3");       // idle bank
            do_req(0, 5, 4, "R2");
            do_req(1, 7, 5, "R6");       // other bank still open
            do_req(0, 9, 6, "R4");       // miss on open bank
            do_req(1, 7, 7, "R6");       // bank 1 unaffected by bank 0 precharge
            do_req(3, 8191, 511, "R3");  // largest row and column
            do_req(3, 0, 0, "R4");
            do_req(0, 9, 0, "R2");
            do_burst(2, 100, 8, "R3");
            do_burst(2, 101, 16, "R4");  // returns overlap the miss sequence
            do_req(2, 101, 24, "R2");
            repeat (40) @(negedge clk);
            chk(head == tail, "R8", "all reads returned", tail - head, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule